// File: doc/BRIEF.md
# Inter-processor interrupt controller

This block lets every processor of a multicore cluster interrupt any other processor and hand it a 16-bit message word at the same time. Each processor owns a private 8-byte window on a simple register bus: a control word at the window's base and a status word four bytes above it. A sender only ever writes its own control word. It names the target processor and the message inside that write. The block works out the sender's identity from which window was addressed.

The receiving processor sees its dedicated interrupt line go high. Its status word then shows a pending flag, the index of the processor that raised the interrupt, and the message. The receiver clears the interrupt by writing an acknowledge into its own control word. The sender index and the message stay readable after the acknowledge. The number of processors is a parameter from 1 to 16. Bus accesses take a single cycle: writes take effect on the clock edge, and read data is returned in the same cycle.

Top module: `ipi_ctrl`

## Requirements
- R1: After reset every interrupt line is low and every status word reads 0.
- R2: A write to processor s's control word (byte address 8·s) with bit 30 set and a destination index d in bits 29:16, where d < NUM_CPU, drives irq[d] high from the next clock edge on.
- R3: After such a generate, processor d's status word (byte address 8·d+4) reads bit 31 = 0, bit 30 = 1 (pending), bits 29:16 = s and bits 15:0 = the data bits 15:0 of the generating write.
- R4: A write of bit 31 = 1 to processor n's own control word clears n's pending flag and drops irq[n] at the next edge. Status bits 29:0 keep their latched values.
- R5: An acknowledge written into one processor's control word has no effect on any other processor's pending state.
- R6: A generate whose destination index is NUM_CPU or higher changes no interrupt line and no status word.
- R7: If one write both acknowledges processor n and generates toward processor n, n stays pending, and its source and data take the new values.
- R8: Reads of any control word return 0. Accesses that are not word aligned or that fall in a window at or above NUM_CPU read 0, and writes to them have no effect.
- R9: A control write with neither bit 31 nor bit 30 set has no effect.
- R10: A generate toward a processor that is already pending keeps it pending and replaces its source and data with those of the latest generate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the strobe |
| irq | output | NUM_CPU | One interrupt line per processor |

## Verification
The bench builds the block with four processors and a 6-bit address. This gives eight windows on the bus, so four of them lie beyond the processor count and can be used to check that out-of-range accesses are ignored. With this small configuration, every sender and receiver pair (all sixteen, including sending to itself) can be tried with a distinct message. After each step, all four status words and all interrupt lines are compared with values worked out from the requirements. Destination indices just past the count and at the field's maximum, the combined acknowledge-and-generate write, and overwriting a pending message are each tested on their own.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int WORD_W     = 32;
    localparam int IDX_W      = 14;
    localparam int MSG_W      = 16;
    localparam int WIN_SHIFT  = 3;   // 8-byte window per processor
    localparam int MAX_CPU    = 16;

    // Control word as written by the sender.
    typedef struct packed {
        logic             ack;   // bit 31
        logic             gen;   // bit 30
        logic [IDX_W-1:0] dst;   // bits 29:16
        logic [MSG_W-1:0] msg;   // bits 15:0
    } ctrl_word_t;

    // Per-processor receive state.
    typedef struct packed {
        logic             pending;
        logic [IDX_W-1:0] src;
        logic [MSG_W-1:0] msg;
    } rx_state_t;

    function automatic logic [WORD_W-1:0] status_word(input rx_state_t st);
        return {1'b0, st.pending, st.src, st.msg};
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 7,
    localparam int WIN_W  = ADDR_W - WIN_SHIFT
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WIN_W-1:0]  win,
    output ctrl_word_t        cword,
    output logic              gen_req,
    output logic              ack_req,
    output logic              stat_rd
);
    logic in_range;
    logic is_stat;

    always_comb begin
        win      = bus_addr[ADDR_W-1:WIN_SHIFT];
        is_stat  = bus_addr[2];
        in_range = bus_sel && (bus_addr[1:0] == 2'b00) && (32'(win) < NUM_CPU);
        cword    = ctrl_word_t'(bus_wdata);
        ack_req  = in_range && bus_we && !is_stat && cword.ack;
        gen_req  = in_range && bus_we && !is_stat && cword.gen
                   && (32'(cword.dst) < NUM_CPU);
        stat_rd  = in_range && !bus_we && is_stat;
    end

endmodule

// File: rtl/ipi_rx_slot.sv
module ipi_rx_slot
    import ipi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_hit,
    input  logic             ack_hit,
    input  logic [IDX_W-1:0] src_in,
    input  logic [MSG_W-1:0] msg_in,
    output rx_state_t        state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (gen_hit) begin
            // generate has priority over a simultaneous acknowledge
            state.pending <= 1'b1;
            state.src     <= src_in;
            state.msg     <= msg_in;
        end else if (ack_hit) begin
            state.pending <= 1'b0;
        end
    end

endmodule

// File: rtl/ipi_readmux.sv
module ipi_readmux
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int WIN_W   = 4
) (
    input  rx_state_t          states [NUM_CPU],
    input  logic               stat_rd,
    input  logic [WIN_W-1:0]   win,
    output logic [WORD_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (stat_rd && (32'(win) == i)) rdata = status_word(states[i]);
        end
    end

endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_CPU-1:0]  irq
);
    localparam int WIN_W = ADDR_W - WIN_SHIFT;

    logic [WIN_W-1:0] win;
    ctrl_word_t       cword;
    logic             gen_req;
    logic             ack_req;
    logic             stat_rd;
    rx_state_t        states [NUM_CPU];

    ipi_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_decode (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .win       (win),
        .cword     (cword),
        .gen_req   (gen_req),
        .ack_req   (ack_req),
        .stat_rd   (stat_rd)
    );

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
        logic gen_hit;
        logic ack_hit;
        assign gen_hit = gen_req && (32'(cword.dst) == g);
        assign ack_hit = ack_req && (32'(win) == g);

        ipi_rx_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .gen_hit (gen_hit),
            .ack_hit (ack_hit),
            .src_in  (IDX_W'(win)),
            .msg_in  (cword.msg),
            .state   (states[g])
        );
        assign irq[g] = states[g].pending;
    end

    ipi_readmux #(.NUM_CPU(NUM_CPU), .WIN_W(WIN_W)) u_readmux (
        .states  (states),
        .stat_rd (stat_rd),
        .win     (win),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/ipi_ctrl_chk.sv
module ipi_ctrl_chk #(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NUM_CPU-1:0] irq
);
    logic        ok_win;
    logic        ctl_wr;
    logic [13:0] c_dst;
    logic [31:0] c_win;

    assign c_win  = 32'(bus_addr[ADDR_W-1:3]);
    assign ok_win = bus_sel && (bus_addr[1:0] == 2'b00) && (c_win < NUM_CPU);
    assign ctl_wr = ok_win && bus_we && !bus_addr[2];
    assign c_dst  = bus_wdata[29:16];

    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (irq == '0));

    a_r8_zero_read: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && !(ok_win && bus_addr[2])) |-> (bus_rdata == 32'd0));

    a_r6_bad_dst: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && !bus_wdata[31] && (32'(c_dst) >= NUM_CPU)) |=> $stable(irq));

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        a_r2_gen_sets: assert property (@(posedge clk) disable iff (rst)
            (ctl_wr && bus_wdata[30] && (32'(c_dst) == i)) |=> irq[i]);

        a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (ctl_wr && bus_wdata[31] && (c_win == i)
             && !(bus_wdata[30] && (32'(c_dst) == i))) |=> !irq[i]);

        a_r7_gen_wins: assert property (@(posedge clk) disable iff (rst)
            (ctl_wr && bus_wdata[31] && bus_wdata[30] && (c_win == i)
             && (32'(c_dst) == i)) |=> irq[i]);

        a_r9_rise_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(ctl_wr && bus_wdata[30] && (32'(c_dst) == i)));
    end

endmodule

bind ipi_ctrl ipi_ctrl_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ipi_ctrl_tb.sv
module ipi_ctrl_tb;
    localparam int N  = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq;

    int total = 0;
    int bad   = 0;

    logic        e_pend [N];
    logic [13:0] e_src  [N];
    logic [15:0] e_msg  [N];

    always #2 clk = ~clk;

    ipi_ctrl #(.NUM_CPU(N), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] q);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
        #1 q = bus_rdata;
    endtask

    function automatic logic [31:0] cw(input bit ack, input bit gen, input int dst, input int msg);
        return {ack, gen, 14'(dst), 16'(msg)};
    endfunction

    // write to sender s's control word and update the expected state
    task automatic send(input int s, input bit ack, input bit gen, input int dst, input int msg);
        wr(8 * s, cw(ack, gen, dst, msg));
        if (ack) e_pend[s] = 1'b0;
        if (gen && dst < N) begin
            e_pend[dst] = 1'b1;
            e_src[dst]  = 14'(s);
            e_msg[dst]  = 16'(msg);
        end
    endtask

    task automatic check_all(input string req);
        logic [31:0] q;
        logic [N-1:0] ev;
        for (int i = 0; i < N; i++) begin
            rd(8 * i + 4, q);
            check(req, q, {1'b0, e_pend[i], e_src[i], e_msg[i]});
            ev[i] = e_pend[i];
        end
        check(req, 32'(irq), 32'(ev));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] q;
        for (int i = 0; i < N; i++) begin
            e_pend[i] = 1'b0; e_src[i] = '0; e_msg[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_all("R1");

        // R2 R3 R4: every sender/receiver pair
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                send(s, 1'b0, 1'b1, d, (s << 12) | (d << 8) | 8'h5A);
                check_all("R2/R3 gen");
                send(d, 1'b1, 1'b0, 0, 0);
                check_all("R4 ack");
            end
        end

        // R5: acknowledge by another processor leaves the target pending
        send(1, 1'b0, 1'b1, 2, 16'hBEEF);
        send(3, 1'b1, 1'b0, 0, 0);
        check_all("R5");
        send(0, 1'b1, 1'b0, 0, 0);
        check_all("R5");

        // R6: destinations at or above the count are ignored
        send(0, 1'b0, 1'b1, N, 16'h1111);
        check_all("R6");
        send(3, 1'b0, 1'b1, 14'h3FFF, 16'h2222);
        check_all("R6");

        // R10: overwrite while pending
        send(1, 1'b0, 1'b1, 0, 16'hA0A0);
        send(3, 1'b0, 1'b1, 0, 16'hC3C3);
        check_all("R10");

        // R7: self ack plus self generate in one write
        send(0, 1'b1, 1'b1, 0, 16'h7777);
        check_all("R7");
        check(32'(irq[0]) == 1 ? "R7" : "R7 irq", 32'(irq[0]), 32'd1);

        // R9: control write without ack or generate
        wr(8 * 0, cw(1'b0, 1'b0, 1, 16'h9999));
        check_all("R9");

        // R8: control reads are zero
        for (int i = 0; i < N; i++) begin
            rd(8 * i, q);
            check("R8 ctrl read", q, 32'd0);
        end
        // R8: out-of-range windows read zero and ignore writes
        rd(8 * N + 4, q);
        check("R8 oor read", q, 32'd0);
        wr(8 * (N + 1), cw(1'b1, 1'b1, 1, 16'h4444));
        check_all("R8 oor write");
        // R8: misaligned access ignored and reads zero
        wr(8 * 2 + 1, cw(1'b0, 1'b1, 2, 16'h5555));
        check_all("R8 misaligned write");
        rd(8 * 0 + 5, q);
        check("R8 misaligned read", q, 32'd0);
        // write to status word has no effect
        wr(8 * 1 + 4, cw(1'b1, 1'b1, 1, 16'h6666));
        check_all("R8 status write");

        // R4: clear the last pending one, data stays
        send(0, 1'b1, 1'b0, 0, 0);
        check_all("R4 final");

        @(negedge clk);
        bus_sel = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule